// File: doc/BRIEF.md
# NAND Asynchronous Bus Cycle Engine

This block sits between a simple memory-mapped register port and the pins of an 8-bit asynchronous NAND flash array of up to eight dies. Every write of one byte into a bank window becomes exactly one flash bus cycle. The cycle kind is set by the offset inside that window: command with CLE high, address with ALE high, or data with both latches low. A read of the data offset becomes one read-strobe cycle and returns the byte captured from the flash.

Two plain registers sit beside the windows. The control register drives the chip-enable pins and the write-protect pin, and reports the synchronised ready/busy line. The strobe timing register sets three phases in core clock cycles: the setup before the strobe falls, the strobe low width, and the hold after it rises. The port stalls the requester until the whole cycle has finished, so flash cycles never overlap.

Address map (12-bit byte address): the control register is at 0x000 and the timing register is at 0x004. The window of bank n is at 0x800 + n*0x100. Inside a window, offset 0x00 is data, 0x04 is address and 0x08 is command.

Top module: `nbe_top`

## Requirements
- R1: After reset all chip enables are high (deasserted), wp_n is low, cle and ale are low, we_n and re_n are high and dq_oe is low. The timing register reads 0x1081. The control register reads 0x300 while rb_n is high.
- R2: Control bits 7:0 drive ce_n as their inverse (a set bit asserts that chip enable). Control bit 8 set drives wp_n low. Control bits 8:0 read back as written.
- R3: Control bit 9 reads rb_n through a two-flop synchroniser. A change on rb_n is not visible to a read accepted in the same cycle, and is visible a few cycles later.
- R4: A write to offset 0x08 of a bank window gives one we_n low pulse. CLE is high and ALE is low for the whole cycle, and dq_out carries the written byte with dq_oe high.
- R5: A write to offset 0x04 of a bank window gives the same cycle with ALE high and CLE low.
- R6: A write to offset 0x00 of a bank window gives a data write cycle with CLE and ALE both low. The byte is on dq_out with dq_oe high.
- R7: A read of offset 0x00 of a bank window gives one re_n low pulse with dq_oe low and we_n high. It returns dq_in, sampled in the last strobe-low cycle, in rdata bits 7:0 with the upper bits zero.
- R8: The timing register holds setup in bits 4:0, strobe width in bits 9:5 and hold in bits 15:10, all in core cycles. A field value of 0 acts as 1. The strobe stays high for exactly setup cycles before falling, stays low for the strobe width, and stays high for hold cycles before ready.
- R9: reg_ready is a one-cycle pulse. A register access completes in the cycle after acceptance. A bank-window cycle raises ready in the cycle after the last hold cycle, and no new request is taken before that.
- R10: A window access whose bank bit is clear in the control CE field, or that uses any other offset (and any window read other than offset 0x00), gives no bus activity. It completes like a register access and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Request held high until reg_ready |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 16 | Write data |
| reg_ready | output | 1 | One-cycle completion pulse |
| reg_rdata | output | 16 | Read data, valid with reg_ready |
| ce_n | output | 8 | Active-low chip enables |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Active-low write strobe |
| re_n | output | 1 | Active-low read strobe |
| wp_n | output | 1 | Active-low write protect |
| dq_out | output | 8 | Flash data bus, outgoing |
| dq_oe | output | 1 | Output enable for dq_out |
| dq_in | input | 8 | Flash data bus, incoming |
| rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
The bench targets the zero-valued timing fields, which must stretch to one cycle. A design that skipped that rule would emit a strobe with no low cycle, or run a phase of 64 cycles. It also drives the widest field values, where an off-by-one counter shows up as one cycle too many or too few in a phase. Window writes to a deselected bank and to unused offsets must leave every strobe and latch idle: a loose decoder would strobe a die that is not enabled, or send a stray command. The ready/busy read taken in the same cycle as an rb_n change must still see the old level; a design without the synchroniser would show the new level at once.

// File: rtl/nbe_pkg.sv
package nbe_pkg;
  typedef enum logic [1:0] {
    CYC_DATA = 2'd0,
    CYC_ADDR = 2'd1,
    CYC_CMD  = 2'd2,
    CYC_NONE = 2'd3
  } cyc_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_PULSE = 3'd2,
    PH_HOLD  = 3'd3,
    PH_DONE  = 3'd4
  } phase_e;

  // A timing field of zero is stretched to one cycle.
  function automatic logic [5:0] eff_count(input logic [5:0] f);
    return (f == 6'd0) ? 6'd1 : f;
  endfunction

  // Offset inside a bank window selects the bus cycle kind.
  function automatic cyc_kind_e window_kind(input logic [7:0] off);
    case (off)
      8'h00:   return CYC_DATA;
      8'h04:   return CYC_ADDR;
      8'h08:   return CYC_CMD;
      default: return CYC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/nbe_regs.sv
module nbe_regs #(
  parameter int NBANK = 8,
  parameter int RW = 16,
  parameter logic [15:0] TIM_RESET = 16'h1081
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_tim,
  input  logic [RW-1:0]    wdata,
  input  logic             rb_n,
  output logic [NBANK:0]   ctrl_q,
  output logic [15:0]      tim_q,
  output logic             rb_sync,
  output logic [5:0]       setup_eff,
  output logic [5:0]       pulse_eff,
  output logic [5:0]       hold_eff
);
  import nbe_pkg::*;

  logic rb_meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= {1'b1, {NBANK{1'b0}}};
      tim_q   <= TIM_RESET;
      rb_meta <= 1'b1;
      rb_sync <= 1'b1;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[NBANK:0];
      if (wr_tim)  tim_q  <= wdata[15:0];
      rb_meta <= rb_n;
      rb_sync <= rb_meta;
    end
  end

  assign setup_eff = eff_count({1'b0, tim_q[4:0]});
  assign pulse_eff = eff_count({1'b0, tim_q[9:5]});
  assign hold_eff  = eff_count(tim_q[15:10]);
endmodule

// File: rtl/nbe_cycle_fsm.sv
module nbe_cycle_fsm #(
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  nbe_pkg::cyc_kind_e   kind,
  input  logic                 is_read,
  input  logic [DW-1:0]        wbyte,
  input  logic [5:0]           setup_eff,
  input  logic [5:0]           pulse_eff,
  input  logic [5:0]           hold_eff,
  input  logic [DW-1:0]        dq_in,
  output logic                 idle,
  output logic                 done,
  output logic                 done_read,
  output logic [DW-1:0]        rbyte,
  output logic                 cle,
  output logic                 ale,
  output logic                 we_n,
  output logic                 re_n,
  output logic                 dq_oe,
  output logic [DW-1:0]        dq_out
);
  import nbe_pkg::*;

  phase_e    phase;
  cyc_kind_e kind_q;
  logic      rd_q;
  logic [DW-1:0] byte_q;
  logic [5:0] cnt;
  logic       cnt_last;
  logic       active;
  logic       strobe_phase;

  assign cnt_last = (cnt == 6'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      kind_q <= CYC_NONE;
      rd_q   <= 1'b0;
      byte_q <= '0;
      rbyte  <= '0;
      cnt    <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_SETUP;
          kind_q <= kind;
          rd_q   <= is_read;
          byte_q <= wbyte;
          cnt    <= setup_eff - 6'd1;
        end
        PH_SETUP: if (cnt_last) begin
          phase <= PH_PULSE;
          cnt   <= pulse_eff - 6'd1;
        end else cnt <= cnt - 6'd1;
        PH_PULSE: if (cnt_last) begin
          phase <= PH_HOLD;
          cnt   <= hold_eff - 6'd1;
          if (rd_q) rbyte <= dq_in;
        end else cnt <= cnt - 6'd1;
        PH_HOLD: if (cnt_last) phase <= PH_DONE;
                 else cnt <= cnt - 6'd1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign idle         = (phase == PH_IDLE);
  assign done         = (phase == PH_DONE);
  assign done_read    = done && rd_q;
  assign active       = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
  assign strobe_phase = (phase == PH_PULSE);
  assign cle    = active && !rd_q && (kind_q == CYC_CMD);
  assign ale    = active && !rd_q && (kind_q == CYC_ADDR);
  assign dq_oe  = active && !rd_q;
  assign we_n   = !(strobe_phase && !rd_q);
  assign re_n   = !(strobe_phase && rd_q);
  assign dq_out = byte_q;

  // R4 R5: the two latch enables never rise together
  a_r4_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  // R7: read and write strobes never overlap
  a_r7_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  // R6: the bus is driven whenever the write strobe is low
  a_r6_driven_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);
  // R7: the bus is released while the read strobe is low
  a_r7_released_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe);
  // R8: a write strobe falls only after at least one driven setup cycle
  a_r8_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(dq_oe));
endmodule

// File: rtl/nbe_top.sv
module nbe_top #(
  parameter int NBANK = 8,
  parameter int AW = 12,
  parameter int RW = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_valid,
  input  logic             reg_write,
  input  logic [AW-1:0]    reg_addr,
  input  logic [RW-1:0]    reg_wdata,
  output logic             reg_ready,
  output logic [RW-1:0]    reg_rdata,
  output logic [NBANK-1:0] ce_n,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic             wp_n,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe,
  input  logic [DW-1:0]    dq_in,
  input  logic             rb_n
);
  import nbe_pkg::*;

  localparam int BANK_BITS = $clog2(NBANK);
  localparam int WIN_SHIFT = 8;

  logic [NBANK:0] ctrl_q;
  logic [15:0]    tim_q;
  logic           rb_sync;
  logic [5:0]     setup_eff, pulse_eff, hold_eff;
  logic           fsm_idle, fsm_done, fsm_done_read;
  logic [DW-1:0]  fsm_rbyte;
  logic           ack_q;
  logic [RW-1:0]  rdata_q;

  logic           accept, is_win, bank_on, bus_start, reg_op, wr_ctrl, wr_tim;
  logic [BANK_BITS-1:0] win_bank;
  cyc_kind_e      kind;

  assign is_win   = reg_addr[AW-1];
  assign win_bank = reg_addr[WIN_SHIFT +: BANK_BITS];
  assign bank_on  = ctrl_q[win_bank];
  assign kind     = window_kind(reg_addr[WIN_SHIFT-1:0]);
  assign accept   = reg_valid && fsm_idle && !ack_q;
  assign bus_start = accept && is_win && bank_on &&
                     (reg_write ? (kind != CYC_NONE) : (kind == CYC_DATA));
  assign reg_op   = accept && !bus_start;
  assign wr_ctrl  = reg_op && reg_write && !is_win && (reg_addr[AW-2:0] == '0);
  assign wr_tim   = reg_op && reg_write && !is_win && (reg_addr[AW-2:0] == 4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= reg_op;
      if (reg_op) begin
        rdata_q <= '0;
        if (!reg_write && !is_win && reg_addr[AW-2:0] == '0)
          rdata_q[NBANK+1:0] <= {rb_sync, ctrl_q};
        else if (!reg_write && !is_win && reg_addr[AW-2:0] == 4)
          rdata_q[15:0] <= tim_q;
      end
    end
  end

  nbe_regs #(.NBANK(NBANK), .RW(RW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_tim(wr_tim),
    .wdata(reg_wdata), .rb_n(rb_n), .ctrl_q(ctrl_q), .tim_q(tim_q),
    .rb_sync(rb_sync), .setup_eff(setup_eff), .pulse_eff(pulse_eff),
    .hold_eff(hold_eff)
  );

  nbe_cycle_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(bus_start), .kind(kind),
    .is_read(!reg_write), .wbyte(reg_wdata[DW-1:0]),
    .setup_eff(setup_eff), .pulse_eff(pulse_eff), .hold_eff(hold_eff),
    .dq_in(dq_in), .idle(fsm_idle), .done(fsm_done),
    .done_read(fsm_done_read), .rbyte(fsm_rbyte), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .dq_oe(dq_oe), .dq_out(dq_out)
  );

  assign ce_n      = ~ctrl_q[NBANK-1:0];
  assign wp_n      = ~ctrl_q[NBANK];
  assign reg_ready = ack_q || fsm_done;
  assign reg_rdata = ack_q ? rdata_q :
                     (fsm_done_read ? {{(RW-DW){1'b0}}, fsm_rbyte} : '0);

  // R9: completion is a single-cycle pulse
  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ready |=> !reg_ready);
  // R9: the two completion sources never coincide
  a_r9_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_q && fsm_done));
  // R10: a register-side completion leaves every strobe idle
  a_r10_quiet_reg_op: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (we_n && re_n && !cle && !ale));
endmodule

// File: tb/nbe_top_bench.sv
`timescale 1ns/1ps
module nbe_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic reg_ready;
  logic [15:0] reg_rdata;
  logic [7:0] ce_n, dq_out;
  logic cle, ale, we_n, re_n, wp_n, dq_oe;
  logic [7:0] dq_in = 8'h00;
  logic rb_n = 1'b1;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  nbe_top u_nbe_top (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ready(reg_ready),
    .reg_rdata(reg_rdata), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
    .rb_n(rb_n)
  );

  typedef struct packed {
    logic [15:0] tim;
    logic [7:0]  off;
    logic [7:0]  byt;
    logic [2:0]  bank;
    logic [5:0]  s;
    logic [5:0]  p;
    logic [5:0]  h;
  } vec_t;

  // Timing word = hold<<10 | pulse<<5 | setup, zero fields count as one.
  localparam vec_t VECS [6] = '{
    '{16'h1081, 8'h08, 8'h90, 3'd0, 6'd1,  6'd4,  6'd4},
    '{16'h0462, 8'h04, 8'h00, 3'd3, 6'd2,  6'd3,  6'd1},
    '{16'h0000, 8'h00, 8'hA5, 3'd7, 6'd1,  6'd1,  6'd1},
    '{16'hFFFF, 8'h08, 8'hFF, 3'd1, 6'd31, 6'd31, 6'd63},
    '{16'h0823, 8'h00, 8'h3C, 3'd5, 6'd3,  6'd1,  6'd2},
    '{16'h0041, 8'h04, 8'h7E, 3'd2, 6'd1,  6'd2,  6'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Observation of one access, sampled on falling edges.
  int o_pre, o_low_we, o_low_re, o_post, o_cle, o_ale, o_oe, o_busy, o_falls;
  logic [7:0] o_dq;
  logic [15:0] o_rd;

  task automatic access(input logic wr, input logic [11:0] a, input logic [15:0] wd);
    logic prev_strobe;
    o_pre = 0; o_low_we = 0; o_low_re = 0; o_post = 0; o_cle = 0; o_ale = 0;
    o_oe = 0; o_busy = 0; o_falls = 0; o_dq = 8'h00;
    prev_strobe = 1'b1;
    @(negedge clk);
    reg_valid = 1'b1; reg_write = wr; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    while (!reg_ready && o_busy < 1000) begin
      o_busy++;
      if (cle) o_cle++;
      if (ale) o_ale++;
      if (dq_oe) o_oe++;
      if (!we_n) begin o_low_we++; o_dq = dq_out; end
      if (!re_n) o_low_re++;
      if (we_n && re_n) begin
        if (o_low_we + o_low_re == 0) o_pre++; else o_post++;
      end
      if (prev_strobe && !(we_n && re_n)) o_falls++;
      prev_strobe = we_n && re_n;
      @(negedge clk);
    end
    o_rd = reg_rdata;
    reg_valid = 1'b0;
    @(negedge clk);
    check("R9 ready pulse width", {31'b0, reg_ready}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the pins
    check("R1 ce_n", {24'b0, ce_n}, 32'hFF);
    check("R1 wp_n", {31'b0, wp_n}, 32'd0);
    check("R1 latches", {30'b0, cle, ale}, 32'd0);
    check("R1 strobes", {30'b0, we_n, re_n}, 32'd3);
    check("R1 dq_oe", {31'b0, dq_oe}, 32'd0);
    access(1'b0, 12'h004, 16'h0);
    check("R1 timing reset", {16'b0, o_rd}, 32'h1081);
    check("R9 register latency", o_busy, 32'd0);
    access(1'b0, 12'h000, 16'h0);
    check("R1 control reset", {16'b0, o_rd}, 32'h300);

    // R2 chip enable and write protect
    access(1'b1, 12'h000, 16'h0004);
    check("R2 ce_n single", {24'b0, ce_n}, 32'hFB);
    check("R2 wp_n released", {31'b0, wp_n}, 32'd1);
    access(1'b1, 12'h000, 16'h0180);
    check("R2 ce_n bank7", {24'b0, ce_n}, 32'h7F);
    check("R2 wp_n active", {31'b0, wp_n}, 32'd0);
    access(1'b0, 12'h000, 16'h0);
    check("R2 readback", {16'b0, o_rd}, 32'h380);

    // R4 R5 R6 R8: vector walk over timings and cycle kinds
    foreach (VECS[i]) begin
      logic is_cmd, is_adr;
      is_cmd = (VECS[i].off == 8'h08);
      is_adr = (VECS[i].off == 8'h04);
      access(1'b1, 12'h000, 16'h0001 << VECS[i].bank);
      access(1'b1, 12'h004, VECS[i].tim);
      access(1'b1, 12'h800 | ({9'b0, VECS[i].bank} << 8) | {4'b0, VECS[i].off},
             {8'h00, VECS[i].byt});
      check($sformatf("R8 setup v%0d", i), o_pre, {26'b0, VECS[i].s});
      check($sformatf("R8 pulse v%0d", i), o_low_we, {26'b0, VECS[i].p});
      check($sformatf("R8 hold v%0d", i), o_post, {26'b0, VECS[i].h});
      check($sformatf("R9 cycle length v%0d", i), o_busy,
            {26'b0, VECS[i].s} + {26'b0, VECS[i].p} + {26'b0, VECS[i].h});
      check($sformatf("R4 one strobe v%0d", i), o_falls, 32'd1);
      check($sformatf("R4 R5 cle v%0d", i), o_cle, is_cmd ? o_busy : 0);
      check($sformatf("R5 ale v%0d", i), o_ale, is_adr ? o_busy : 0);
      check($sformatf("R6 driven v%0d", i), o_oe, o_busy);
      check($sformatf("R6 byte v%0d", i), {24'b0, o_dq}, {24'b0, VECS[i].byt});
      check($sformatf("R7 no read strobe v%0d", i), o_low_re, 32'd0);
    end

    // R7 read cycle on bank 4, timing 0x1081
    access(1'b1, 12'h000, 16'h0010);
    access(1'b1, 12'h004, 16'h1081);
    dq_in = 8'h5A;
    access(1'b0, 12'hC00, 16'h0);
    check("R7 read data", {16'b0, o_rd}, 32'h005A);
    check("R7 one read strobe", o_falls, 32'd1);
    check("R7 strobe width", o_low_re, 32'd4);
    check("R7 no write strobe", o_low_we, 32'd0);
    check("R7 bus released", o_oe, 32'd0);
    check("R7 no latches", o_cle + o_ale, 32'd0);
    dq_in = 8'hC3;
    access(1'b0, 12'hC00, 16'h0);
    check("R7 second read", {16'b0, o_rd}, 32'h00C3);

    // R10 deselected bank and unused offsets
    access(1'b1, 12'hD08, 16'h00FF);
    check("R10 deselected bank quiet", o_falls + o_cle, 32'd0);
    check("R10 deselected latency", o_busy, 32'd0);
    access(1'b1, 12'hC0C, 16'h0011);
    check("R10 unused offset quiet", o_falls + o_oe, 32'd0);
    access(1'b0, 12'hC08, 16'h0);
    check("R10 read of command offset", {16'b0, o_rd}, 32'd0);
    check("R10 no read strobe", o_low_re, 32'd0);

    // R3 ready/busy synchroniser
    @(negedge clk);
    rb_n = 1'b0;
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = 12'h000;
    @(negedge clk);
    check("R3 same-cycle read old", {31'b0, reg_rdata[9]}, 32'd1);
    reg_valid = 1'b0;
    repeat (3) @(negedge clk);
    access(1'b0, 12'h000, 16'h0);
    check("R3 busy visible", {31'b0, o_rd[9]}, 32'd0);
    rb_n = 1'b1;
    repeat (3) @(negedge clk);
    access(1'b0, 12'h000, 16'h0);
    check("R3 ready visible", {31'b0, o_rd[9]}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule